// File: doc/BRIEF.md
# Translation context selector

This block decides, for one memory access, which privilege level the address translation must honour and which of two translation register sets (the normal set or the background set that describes a guest) the page walker should read. It also tells the walker when no walk is needed at all: the access then maps one-to-one onto physical memory and is granted read, write and execute permission.

The decision is purely combinational. It runs in three steps. A machine-level step lets data accesses borrow a saved privilege. A hypervisor-level step lets supervisor data accesses borrow the saved supervisor privilege and guest tables. A final step forces user privilege for a second-stage lookup and derives the bypass flag. Instruction fetches skip both borrowing steps. The three steps have no named states or transitions. The block holds no state and has no clock or reset.

Top module: `xlate_ctx_sel`

## Requirements
- R1: Privilege codes are U=0, S=1, M=3. Code 2 on `cur_priv` or `mm_saved_priv` is read as U. `eff_priv` never shows 2.
- R2: When the normalised current privilege is M, the access is not a fetch and `mm_borrow` is 1, the effective privilege becomes the normalised `mm_saved_priv`.
- R3: In the R2 case, `use_guest_regs` is 1 exactly when `hyp_present` and `mm_saved_virt` are both 1. Outside the R2 and R4 cases it stays 0.
- R4: When the privilege after R2 is S, the access is not a fetch, `hyp_present` is 1, `virt_on` is 0 and `hs_borrow` is 1, the effective privilege becomes S if `ss_saved_priv` is 1 and U otherwise, and `use_guest_regs` becomes 1. This step also applies to the result of an R2 borrow. It does not apply when the privilege after R2 is U.
- R5: The R4 step is not taken when `virt_on` is 1 or `hyp_present` is 0. Privilege and register select then keep their post-R2 values.
- R6: Access kind codes are 0 fetch, 1 load, 2 store and 3 other data access. A fetch gives `eff_priv` equal to the normalised `cur_priv` and `use_guest_regs` 0, whatever the borrow bits are.
- R7: With `stage_two` at 1, `eff_priv` is U. `use_guest_regs` is left as R2 to R5 set it.
- R8: `bypass` is 1 exactly when `eff_priv` is M or `mmu_present` is 0.
- R9: With both borrow bits at 0, `eff_priv` is the normalised `cur_priv` (or U under R7) and `use_guest_regs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_priv | input | 2 | Current privilege level |
| access_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 other data |
| mm_borrow | input | 1 | Machine-level modify-privilege bit |
| mm_saved_priv | input | 2 | Machine saved previous privilege |
| mm_saved_virt | input | 1 | Machine saved previous virtualization bit |
| hs_borrow | input | 1 | Hypervisor-level modify-privilege bit |
| ss_saved_priv | input | 1 | Supervisor saved previous privilege (1 = S) |
| hyp_present | input | 1 | Hypervisor extension present |
| virt_on | input | 1 | Virtualization currently active |
| stage_two | input | 1 | Lookup is the second translation stage |
| mmu_present | input | 1 | Translation hardware present |
| eff_priv | output | 2 | Effective privilege for the walk |
| use_guest_regs | output | 1 | 1 selects the background register set |
| bypass | output | 1 | Identity mapping with full permissions |

## Verification
Whenever the inputs change, the embedded checks confirm four things. A fetch never borrows a privilege. A background select only arises from an allowed source. A second-stage lookup always comes out as U. The reserved code never reaches the output. Only the bench's vectors can show which exact privilege a borrow produces and how the two borrow steps chain. These include an M access redirected to S and then redirected again by the hypervisor bit, and the reserved code appearing in the saved-privilege field.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
    localparam int PRIV_W = 2;
    localparam int ACC_W  = 2;

    typedef enum logic [PRIV_W-1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [ACC_W-1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    // reserved code folds onto user level
    function automatic priv_e norm_priv(input logic [PRIV_W-1:0] raw);
        priv_e r;
        unique case (raw)
            2'd1:    r = PRIV_S;
            2'd3:    r = PRIV_M;
            default: r = PRIV_U;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xctx_mach_stage.sv
module xctx_mach_stage
    import xctx_pkg::*;
(
    input  priv_e cur_priv,
    input  logic  is_fetch,
    input  logic  mm_borrow,
    input  priv_e mm_saved_priv,
    input  logic  mm_saved_virt,
    input  logic  hyp_present,
    output priv_e priv_o,
    output logic  bg_o
);
    logic take;

    always_comb begin
        take   = (cur_priv == PRIV_M) && !is_fetch && mm_borrow;
        priv_o = take ? mm_saved_priv : cur_priv;
        bg_o   = take && hyp_present && mm_saved_virt;
    end

    always_comb begin
        // R6
        fetch_no_mach_borrow_chk: assert (!is_fetch || (priv_o == cur_priv && !bg_o))
            else $error("fetch took machine borrow");
        // R3
        mach_bg_source_chk: assert (!bg_o || (hyp_present && mm_saved_virt && mm_borrow))
            else $error("background select without machine source");
    end
endmodule

// File: rtl/xctx_hyp_stage.sv
module xctx_hyp_stage
    import xctx_pkg::*;
(
    input  priv_e priv_i,
    input  logic  bg_i,
    input  logic  is_fetch,
    input  logic  hyp_present,
    input  logic  virt_on,
    input  logic  hs_borrow,
    input  logic  ss_saved_priv,
    output priv_e priv_o,
    output logic  bg_o
);
    logic take;

    always_comb begin
        take   = (priv_i == PRIV_S) && !is_fetch && hyp_present && !virt_on && hs_borrow;
        priv_o = take ? (ss_saved_priv ? PRIV_S : PRIV_U) : priv_i;
        bg_o   = take | bg_i;
    end

    always_comb begin
        // R5
        hyp_gate_chk: assert (!(virt_on || !hyp_present) || (priv_o == priv_i && bg_o == bg_i))
            else $error("hypervisor borrow taken while gated");
        // R6
        fetch_no_hyp_borrow_chk: assert (!is_fetch || (priv_o == priv_i && bg_o == bg_i))
            else $error("fetch took hypervisor borrow");
    end
endmodule

// File: rtl/xctx_final_stage.sv
module xctx_final_stage
    import xctx_pkg::*;
(
    input  priv_e priv_i,
    input  logic  stage_two,
    input  logic  mmu_present,
    output priv_e eff_priv,
    output logic  bypass
);
    always_comb begin
        eff_priv = stage_two ? PRIV_U : priv_i;
        bypass   = (eff_priv == PRIV_M) || !mmu_present;
    end

    always_comb begin
        // R7
        stage_two_user_chk: assert (!stage_two || eff_priv == PRIV_U)
            else $error("second stage not user");
        // R1
        no_reserved_out_chk: assert (eff_priv != PRIV_RSV)
            else $error("reserved privilege on output");
        // R8
        mmu_absent_bypass_chk: assert (mmu_present || bypass)
            else $error("no bypass without translation hardware");
    end
endmodule

// File: rtl/xlate_ctx_sel.sv
module xlate_ctx_sel
    import xctx_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic [1:0] access_kind,
    input  logic       mm_borrow,
    input  logic [1:0] mm_saved_priv,
    input  logic       mm_saved_virt,
    input  logic       hs_borrow,
    input  logic       ss_saved_priv,
    input  logic       hyp_present,
    input  logic       virt_on,
    input  logic       stage_two,
    input  logic       mmu_present,
    output logic [1:0] eff_priv,
    output logic       use_guest_regs,
    output logic       bypass
);
    priv_e cur_n, saved_n, m_priv, h_priv, f_priv;
    logic  is_fetch, m_bg, h_bg;

    always_comb begin
        cur_n    = norm_priv(cur_priv);
        saved_n  = norm_priv(mm_saved_priv);
        is_fetch = (acc_e'(access_kind) == ACC_FETCH);
    end

    xctx_mach_stage u_mach (
        .cur_priv     (cur_n),
        .is_fetch     (is_fetch),
        .mm_borrow    (mm_borrow),
        .mm_saved_priv(saved_n),
        .mm_saved_virt(mm_saved_virt),
        .hyp_present  (hyp_present),
        .priv_o       (m_priv),
        .bg_o         (m_bg)
    );

    xctx_hyp_stage u_hyp (
        .priv_i       (m_priv),
        .bg_i         (m_bg),
        .is_fetch     (is_fetch),
        .hyp_present  (hyp_present),
        .virt_on      (virt_on),
        .hs_borrow    (hs_borrow),
        .ss_saved_priv(ss_saved_priv),
        .priv_o       (h_priv),
        .bg_o         (h_bg)
    );

    xctx_final_stage u_final (
        .priv_i     (h_priv),
        .stage_two  (stage_two),
        .mmu_present(mmu_present),
        .eff_priv   (f_priv),
        .bypass     (bypass)
    );

    assign eff_priv       = f_priv;
    assign use_guest_regs = h_bg;

    always_comb begin
        // R9
        no_borrow_no_bg_chk: assert (mm_borrow || hs_borrow || !use_guest_regs)
            else $error("background select with no borrow bit");
    end
endmodule

// File: tb/xlate_ctx_sel_tb.sv
module xlate_ctx_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0] cur_priv, access_kind, mm_saved_priv, eff_priv;
    logic mm_borrow, mm_saved_virt, hs_borrow, ss_saved_priv;
    logic hyp_present, virt_on, stage_two, mmu_present;
    logic use_guest_regs, bypass;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    xlate_ctx_sel u_dut (
        .cur_priv(cur_priv), .access_kind(access_kind), .mm_borrow(mm_borrow),
        .mm_saved_priv(mm_saved_priv), .mm_saved_virt(mm_saved_virt),
        .hs_borrow(hs_borrow), .ss_saved_priv(ss_saved_priv),
        .hyp_present(hyp_present), .virt_on(virt_on), .stage_two(stage_two),
        .mmu_present(mmu_present), .eff_priv(eff_priv),
        .use_guest_regs(use_guest_regs), .bypass(bypass)
    );

    // fields: cur acc mborrow msaved mvirt hborrow ssaved hyp virt st2 mmu | eff bg byp
    localparam logic [17:0] VEC [NVEC] = '{
        18'b00_01_0_00_0_0_0_0_0_0_1_00_0_0, // R9 U load plain
        18'b11_01_0_00_0_0_0_0_0_0_1_11_0_1, // R8 M load bypass
        18'b11_01_1_01_0_0_0_0_0_0_1_01_0_0, // R2 M borrow to S
        18'b11_10_1_00_1_0_0_1_0_0_1_00_1_0, // R3 guest regs
        18'b11_10_1_00_1_0_0_0_0_0_1_00_0_0, // R3 no hypervisor
        18'b11_00_1_00_1_0_0_1_0_0_1_11_0_1, // R6 fetch ignores borrow
        18'b01_01_0_00_0_1_1_1_0_0_1_01_1_0, // R4 S borrow saved S
        18'b01_10_0_00_0_1_0_1_0_0_1_00_1_0, // R4 S borrow saved U
        18'b01_01_0_00_0_1_0_1_1_0_1_01_0_0, // R5 virt on
        18'b01_01_0_00_0_1_0_0_0_0_1_01_0_0, // R5 no hypervisor
        18'b01_00_0_00_0_1_0_1_0_0_1_01_0_0, // R6 S fetch
        18'b11_01_1_01_0_1_0_1_0_0_1_00_1_0, // R4 chained M->S->U
        18'b11_01_0_00_0_0_0_0_0_1_1_00_0_0, // R7 stage two
        18'b11_10_1_00_1_0_0_1_0_1_1_00_1_0, // R7 bg kept
        18'b00_01_0_00_0_0_0_0_0_0_0_00_0_1, // R8 no mmu
        18'b10_01_0_00_0_0_0_0_0_0_1_00_0_0, // R1 reserved current
        18'b11_01_1_10_0_0_0_0_0_0_1_00_0_0, // R1 reserved saved
        18'b11_01_1_11_0_0_0_0_0_0_1_11_0_1, // R2 borrow to M
        18'b11_11_1_01_0_0_0_0_0_0_1_01_0_0, // R6 kind 3 is data
        18'b00_01_0_00_0_1_1_1_0_0_1_00_0_0  // R4 U not redirected
    };
    localparam int TAG [NVEC] = '{9,8,2,3,3,6,4,4,5,5,6,4,7,7,8,1,1,2,6,4};

    task automatic apply(input logic [13:0] v);
        @(negedge clk);
        {cur_priv, access_kind, mm_borrow, mm_saved_priv, mm_saved_virt,
         hs_borrow, ss_saved_priv, hyp_present, virt_on, stage_two, mmu_present} = v;
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input int tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got eff/bg/byp=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] norm(input logic [1:0] p);
        return (p == 2'd2) ? 2'd0 : p;
    endfunction

    initial begin
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][17:4]);
            check(TAG[i], {eff_priv, use_guest_regs, bypass}, VEC[i][3:0]);
        end
        // R6 sweep: fetches with every borrow setting keep the current level
        for (int k = 0; k < 256; k++) begin
            logic [7:0] s = k[7:0];
            apply({s[1:0], 2'b00, s[2], s[4:3], s[5], s[6], s[7], 1'b1, 1'b0, 1'b0, 1'b1});
            check(6, {eff_priv, use_guest_regs, bypass},
                  {norm(s[1:0]), 1'b0, norm(s[1:0]) == 2'd3});
        end
        // R7 sweep: second stage always user, bypass only without mmu
        for (int k = 0; k < 128; k++) begin
            logic [6:0] s = k[6:0];
            apply({2'b11, 2'b01, s[0], s[2:1], s[3], s[4], 1'b0, s[5], 1'b0, 1'b1, s[6]});
            check(7, {eff_priv, bypass}, {2'b00, ~s[6]});
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule